// File: doc/BRIEF.md
# Single-Unit DMA Transfer Engine

This block moves one transfer unit for one DMA channel each time it is asked to. A register block outside it owns the channel's programmed and working registers. It presents the current source address, the destination address, the remaining unit count and the control fields, then pulses a step request. The engine captures these values. It aligns both addresses to the unit size and issues a read on a simple valid/ready bus master port. It holds the read data in an internal latch and writes that data to the destination. It then returns the advanced addresses and the decremented count, so the register block can store them back.

The source read is skipped when the aligned source address falls below a configurable floor. In that case the latch keeps whatever was captured last, and that value is written again. For 16-bit units the written halfword comes from the latch rotated by the destination's byte lane. When the count runs out, the engine reports the end of the block. It raises a one-cycle interrupt pulse when interrupts are enabled, and it asks for the channel enable to be cleared unless the repeat bit is set. Triggering, register decoding and count reload are handled by the surrounding logic.

Top module: `dma_unit_engine`

## Requirements
- R1: With `cfg_wide`=1 the unit is 32 bits and the address stride is 4 bytes. With `cfg_wide`=0 the unit is 16 bits and the stride is 2 bytes. `bus_req_wide` follows `cfg_wide` on every bus request of the step.
- R2: Bus addresses are the working addresses with bits [1:0] cleared for 32-bit units, or bit 0 cleared for 16-bit units. The returned next addresses are computed from the unaligned working addresses.
- R3: A read of the aligned source happens before the write only when that address is at or above `SRC_FLOOR` (default 0x0200_0000). Otherwise no read is issued and the write reuses the latch from an earlier step.
- R4: A 32-bit read stores all of `bus_rdata` in the latch, and a 16-bit read stores `bus_rdata[15:0]` zero-extended. A 32-bit write sends the latch unchanged. A 16-bit write sends the latch rotated right by 8 times bits [1:0] of the aligned destination, keeps the low 16 bits and sets bits [31:16] to zero.
- R5: The adjust codes are 0 = add stride, 1 = subtract stride and 2 = hold. The result wraps modulo 2^32.
- R6: Source adjust code 3 leaves the source unchanged and raises `src_adj_err` in the done cycle. Destination adjust code 3 adds the stride like code 0.
- R7: Each completed step returns `cnt_out` = captured count minus 1, modulo 2^CNT_W.
- R8: A step whose captured count is 1 pulses `blk_end` for one cycle with `done`. It also pulses `irq` for that single cycle if `cfg_irq_en` was set at capture. Other steps pulse neither signal.
- R9: `en_clr` pulses with `blk_end` exactly when the captured repeat bit `cfg_repeat` is 0.
- R10: A request stays valid with a stable address until `bus_req_ready`. `done` rises one cycle after the write is accepted, with `busy` already low. `step_req` is ignored while busy, and inputs that change after capture have no effect on the step.
- R11: After reset, no bus request is valid, all pulses are low, and `src_out`, `dst_out` and `cnt_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_req | input | 1 | Request one unit; taken when idle |
| cfg_wide | input | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| cfg_src_adj | input | 2 | Source adjust code |
| cfg_dst_adj | input | 2 | Destination adjust code |
| cfg_irq_en | input | 1 | Interrupt on block end |
| cfg_repeat | input | 1 | Keep channel enabled at block end |
| src_in | input | ADDR_W | Working source address |
| dst_in | input | ADDR_W | Working destination address |
| cnt_in | input | CNT_W | Remaining units |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_wide | output | 1 | Access size, 1 = 32 bits |
| bus_req_addr | output | ADDR_W | Aligned access address |
| bus_req_wdata | output | DATA_W | Write data |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_rdata | input | DATA_W | Read data, valid with ready on a read |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle pulse at step completion |
| src_out | output | ADDR_W | Advanced source address |
| dst_out | output | ADDR_W | Advanced destination address |
| cnt_out | output | CNT_W | Decremented count |
| blk_end | output | 1 | Count reached zero |
| irq | output | 1 | Interrupt pulse |
| en_clr | output | 1 | Request to clear channel enable |
| src_adj_err | output | 1 | Prohibited source adjust code used |

## Verification
A corrupted latch is visible in the write data of the very next step, or of the first step after that whose source lies below the floor, since that step writes the stale value directly. A wrong alignment or stride shows on `bus_req_addr` within the same step, and in `src_out`/`dst_out` in the done cycle. A miscounted remainder or a wrongly captured control bit shows in the done cycle of the step that ends the block: `blk_end`, `irq` or `en_clr` is missing there, or one of them fires a step early. The sweep crosses every size, adjust code pair, lane and floor side, and it stalls the bus in some steps, so each of these faults is exposed within one or two steps.

// File: rtl/dma_unit_pkg.sv
`timescale 1ns/1ps
package dma_unit_pkg;
   typedef enum logic [1:0] {
      ADJ_INC     = 2'd0,
      ADJ_DEC     = 2'd1,
      ADJ_HOLD    = 2'd2,
      ADJ_INC_RLD = 2'd3
   } adj_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } phase_e;
endpackage

// File: rtl/dma_addr_step.sv
`timescale 1ns/1ps
module dma_addr_step
   import dma_unit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter bit IS_SRC = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wide_i,
   input  adj_e              adj_i,
   output logic [ADDR_W-1:0] aligned_o,
   output logic [ADDR_W-1:0] next_o,
   output logic              err_o
);
   logic [ADDR_W-1:0] stride;

   assign stride    = wide_i ? ADDR_W'(4) : ADDR_W'(2);
   assign aligned_o = wide_i ? {addr_i[ADDR_W-1:2], 2'b00}
                             : {addr_i[ADDR_W-1:1], 1'b0};

   generate
      if (IS_SRC) begin : g_src
         always_comb begin
            err_o = 1'b0;
            case (adj_i)
               ADJ_INC:  next_o = addr_i + stride;
               ADJ_DEC:  next_o = addr_i - stride;
               ADJ_HOLD: next_o = addr_i;
               default: begin
                  next_o = addr_i;
                  err_o  = 1'b1;
               end
            endcase
         end
      end else begin : g_dst
         always_comb begin
            err_o = 1'b0;
            case (adj_i)
               ADJ_DEC:  next_o = addr_i - stride;
               ADJ_HOLD: next_o = addr_i;
               default:  next_o = addr_i + stride;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/dma_lane_rotate.sv
`timescale 1ns/1ps
module dma_lane_rotate #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] latch_i,
   input  logic              wide_i,
   input  logic [1:0]        lane_i,
   output logic [DATA_W-1:0] wdata_o
);
   localparam int LANES = 4;
   localparam int HALF  = 16;

   logic [DATA_W-1:0] rot [LANES];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_rot
         logic [2*DATA_W-1:0] dbl;
         assign dbl    = {latch_i, latch_i} >> (8 * k);
         assign rot[k] = dbl[DATA_W-1:0];
      end
   endgenerate

   assign wdata_o = wide_i ? latch_i
                           : {{(DATA_W-HALF){1'b0}}, rot[lane_i][HALF-1:0]};
endmodule

// File: rtl/dma_unit_fsm.sv
`timescale 1ns/1ps
module dma_unit_fsm
   import dma_unit_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step_req,
   input  logic src_hi,
   input  logic bus_ready,
   output logic capture,
   output logic rd_valid,
   output logic wr_valid,
   output logic rd_fire,
   output logic wr_fire,
   output logic busy
);
   phase_e ph, ph_nxt;

   assign capture  = (ph == PH_IDLE) && step_req;
   assign rd_valid = (ph == PH_READ) && src_hi;
   assign wr_valid = (ph == PH_WRITE);
   assign rd_fire  = rd_valid && bus_ready;
   assign wr_fire  = wr_valid && bus_ready;
   assign busy     = (ph != PH_IDLE);

   always_comb begin
      ph_nxt = ph;
      case (ph)
         PH_IDLE:  if (step_req) ph_nxt = PH_READ;
         PH_READ:  if (!src_hi || bus_ready) ph_nxt = PH_WRITE;
         PH_WRITE: if (bus_ready) ph_nxt = PH_IDLE;
         default:  ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_IDLE;
      else        ph <= ph_nxt;
   end
endmodule

// File: rtl/dma_unit_engine.sv
`timescale 1ns/1ps
module dma_unit_engine
   import dma_unit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 14,
   parameter logic [ADDR_W-1:0] SRC_FLOOR = ADDR_W'(32'h0200_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_req,
   input  logic              cfg_wide,
   input  logic [1:0]        cfg_src_adj,
   input  logic [1:0]        cfg_dst_adj,
   input  logic              cfg_irq_en,
   input  logic              cfg_repeat,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic              bus_req_valid,
   output logic              bus_req_write,
   output logic              bus_req_wide,
   output logic [ADDR_W-1:0] bus_req_addr,
   output logic [DATA_W-1:0] bus_req_wdata,
   input  logic              bus_req_ready,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] src_out,
   output logic [ADDR_W-1:0] dst_out,
   output logic [CNT_W-1:0]  cnt_out,
   output logic              blk_end,
   output logic              irq,
   output logic              en_clr,
   output logic              src_adj_err
);
   localparam int HALF = 16;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("dma_unit_engine: DATA_W must be 32");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("dma_unit_engine: CNT_W must be 2..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("dma_unit_engine: ADDR_W must be 8..32");
      end
   endgenerate

   // captured step context
   logic              wide_q, irq_en_q, rep_q;
   adj_e              sadj_q, dadj_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] latch_q;

   logic              capture, rd_valid, wr_valid, rd_fire, wr_fire;
   logic [ADDR_W-1:0] src_al, src_nx, dst_al, dst_nx;
   logic              src_err, dst_err, src_hi, last_unit;
   logic [DATA_W-1:0] wdata_rot;

   dma_unit_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_req  (step_req),
      .src_hi    (src_hi),
      .bus_ready (bus_req_ready),
      .capture   (capture),
      .rd_valid  (rd_valid),
      .wr_valid  (wr_valid),
      .rd_fire   (rd_fire),
      .wr_fire   (wr_fire),
      .busy      (busy)
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .IS_SRC(1'b1)) u_src_step (
      .addr_i    (src_q),
      .wide_i    (wide_q),
      .adj_i     (sadj_q),
      .aligned_o (src_al),
      .next_o    (src_nx),
      .err_o     (src_err)
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .IS_SRC(1'b0)) u_dst_step (
      .addr_i    (dst_q),
      .wide_i    (wide_q),
      .adj_i     (dadj_q),
      .aligned_o (dst_al),
      .next_o    (dst_nx),
      .err_o     (dst_err)
   );

   dma_lane_rotate #(.DATA_W(DATA_W)) u_rot (
      .latch_i (latch_q),
      .wide_i  (wide_q),
      .lane_i  (dst_al[1:0]),
      .wdata_o (wdata_rot)
   );

   assign src_hi    = (src_al >= SRC_FLOOR);
   assign last_unit = (cnt_q == CNT_ONE);

   assign bus_req_valid = rd_valid || wr_valid;
   assign bus_req_write = wr_valid;
   assign bus_req_wide  = bus_req_valid && wide_q;
   assign bus_req_addr  = wr_valid ? dst_al : (rd_valid ? src_al : '0);
   assign bus_req_wdata = wr_valid ? wdata_rot : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q   <= 1'b0;
         irq_en_q <= 1'b0;
         rep_q    <= 1'b0;
         sadj_q   <= ADJ_INC;
         dadj_q   <= ADJ_INC;
         src_q    <= '0;
         dst_q    <= '0;
         cnt_q    <= '0;
      end else if (capture) begin
         wide_q   <= cfg_wide;
         irq_en_q <= cfg_irq_en;
         rep_q    <= cfg_repeat;
         sadj_q   <= adj_e'(cfg_src_adj);
         dadj_q   <= adj_e'(cfg_dst_adj);
         src_q    <= src_in;
         dst_q    <= dst_in;
         cnt_q    <= cnt_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (rd_fire) begin
         latch_q <= wide_q ? bus_rdata
                           : {{(DATA_W-HALF){1'b0}}, bus_rdata[HALF-1:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_out     <= '0;
         dst_out     <= '0;
         cnt_out     <= '0;
         done        <= 1'b0;
         blk_end     <= 1'b0;
         irq         <= 1'b0;
         en_clr      <= 1'b0;
         src_adj_err <= 1'b0;
      end else begin
         done        <= wr_fire;
         blk_end     <= wr_fire && last_unit;
         irq         <= wr_fire && last_unit && irq_en_q;
         en_clr      <= wr_fire && last_unit && !rep_q;
         src_adj_err <= wr_fire && (src_err || dst_err);
         if (wr_fire) begin
            src_out <= src_nx;
            dst_out <= dst_nx;
            cnt_out <= cnt_q - CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/dma_unit_engine_chk.sv
`timescale 1ns/1ps
module dma_unit_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 14,
   parameter logic [ADDR_W-1:0] SRC_FLOOR = ADDR_W'(32'h0200_0000)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_req,
   input logic              cfg_wide,
   input logic [1:0]        cfg_src_adj,
   input logic [1:0]        cfg_dst_adj,
   input logic              cfg_irq_en,
   input logic              cfg_repeat,
   input logic [ADDR_W-1:0] src_in,
   input logic [ADDR_W-1:0] dst_in,
   input logic [CNT_W-1:0]  cnt_in,
   input logic              bus_req_valid,
   input logic              bus_req_write,
   input logic              bus_req_wide,
   input logic [ADDR_W-1:0] bus_req_addr,
   input logic [DATA_W-1:0] bus_req_wdata,
   input logic              bus_req_ready,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] src_out,
   input logic [ADDR_W-1:0] dst_out,
   input logic [CNT_W-1:0]  cnt_out,
   input logic              blk_end,
   input logic              irq,
   input logic              en_clr,
   input logic              src_adj_err
);
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_req_ready |=>
         bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write));

   assert_align_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_req_wide |-> bus_req_addr[1:0] == 2'b00);

   assert_align_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_req_wide |-> !bus_req_addr[0]);

   assert_no_low_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_req_write |-> bus_req_addr >= SRC_FLOOR);

   assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_req_write && !bus_req_wide |->
         bus_req_wdata[DATA_W-1:16] == '0);

   assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_req_valid && bus_req_ready && bus_req_write) && !busy);

   assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> blk_end && done && cnt_out == '0);

   assert_enclr_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |-> blk_end);

   assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      src_adj_err |-> done);
endmodule

bind dma_unit_engine dma_unit_engine_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SRC_FLOOR(SRC_FLOOR)
) chk_i (.*);

// File: tb/dma_unit_engine_tb_top.sv
`timescale 1ns/1ps
module dma_unit_engine_tb_top;
   localparam logic [31:0] FLOOR = 32'h0200_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_req = 1'b0;
   logic        cfg_wide = 1'b0, cfg_irq_en = 1'b0, cfg_repeat = 1'b0;
   logic [1:0]  cfg_src_adj = 2'd0, cfg_dst_adj = 2'd0;
   logic [31:0] src_in = '0, dst_in = '0;
   logic [13:0] cnt_in = '0;
   logic        bus_req_valid, bus_req_write, bus_req_wide;
   logic [31:0] bus_req_addr, bus_req_wdata, bus_rdata;
   logic        bus_req_ready = 1'b1;
   logic        busy, done, blk_end, irq, en_clr, src_adj_err;
   logic [31:0] src_out, dst_out;
   logic [13:0] cnt_out;

   int checks = 0;
   int errors = 0;
   logic [31:0] mlatch = '0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] mem_f(input logic [31:0] a);
      return (a * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
   endfunction

   assign bus_rdata = mem_f(bus_req_addr);

   dma_unit_engine dut_i (
      .clk(clk), .rst_n(rst_n), .step_req(step_req), .cfg_wide(cfg_wide),
      .cfg_src_adj(cfg_src_adj), .cfg_dst_adj(cfg_dst_adj),
      .cfg_irq_en(cfg_irq_en), .cfg_repeat(cfg_repeat),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
      .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
      .bus_req_wide(bus_req_wide), .bus_req_addr(bus_req_addr),
      .bus_req_wdata(bus_req_wdata), .bus_req_ready(bus_req_ready),
      .bus_rdata(bus_rdata), .busy(busy), .done(done),
      .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
      .blk_end(blk_end), .irq(irq), .en_clr(en_clr), .src_adj_err(src_adj_err)
   );

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] half_of(input logic [31:0] l, input logic [1:0] lane);
      case (lane)
         2'd0:    return {16'h0, l[15:0]};
         2'd1:    return {16'h0, l[23:8]};
         2'd2:    return {16'h0, l[31:16]};
         default: return {16'h0, l[7:0], l[31:24]};
      endcase
   endfunction

   task automatic run_step(input bit w, input logic [1:0] sa, input logic [1:0] da,
                           input bit ie, input bit rp, input logic [31:0] s,
                           input logic [31:0] d, input logic [13:0] c,
                           input bit stall, input bit hold);
      int nr = 0, nw = 0;
      bit got = 1'b0;
      logic [31:0] raddr = '0, waddr = '0, wdata = '0, wwide = '0;
      logic [31:0] stride, mask, sal, dal, exp_src, exp_dst, exp_wd;
      bit rd_exp, last;

      @(negedge clk);
      cfg_wide = w; cfg_src_adj = sa; cfg_dst_adj = da;
      cfg_irq_en = ie; cfg_repeat = rp;
      src_in = s; dst_in = d; cnt_in = c;
      step_req = 1'b1;
      @(negedge clk);
      if (!hold) step_req = 1'b0;
      else begin
         src_in = ~s; dst_in = ~d; cnt_in = c + 14'd5;
         cfg_wide = ~w; cfg_irq_en = ~ie; cfg_repeat = ~rp;
      end
      for (int n = 0; n < 60 && !got; n++) begin
         bus_req_ready = stall ? ((n % 3) == 2) : 1'b1;
         #1;
         if (done) begin
            got = 1'b1;
            step_req = 1'b0;
         end else begin
            if (bus_req_valid && bus_req_ready) begin
               if (bus_req_write) begin
                  nw++; waddr = bus_req_addr; wdata = bus_req_wdata;
                  wwide = {31'h0, bus_req_wide};
               end else begin
                  nr++; raddr = bus_req_addr;
               end
            end
            @(negedge clk);
         end
      end
      check_eq("R10 step completes", {31'h0, got}, 32'h1);

      // model from the requirements
      stride = w ? 32'd4 : 32'd2;
      mask   = w ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;
      sal = s & mask; dal = d & mask;
      rd_exp = (sal >= FLOOR);
      if (rd_exp) mlatch = w ? mem_f(sal) : {16'h0, mem_f(sal)[15:0]};
      exp_wd = w ? mlatch : half_of(mlatch, dal[1:0]);
      case (sa)
         2'd0: exp_src = s + stride;
         2'd1: exp_src = s - stride;
         default: exp_src = s;
      endcase
      case (da)
         2'd1: exp_dst = d - stride;
         2'd2: exp_dst = d;
         default: exp_dst = d + stride;
      endcase
      last = (c == 14'd1);

      check_eq("R3 read count", nr, rd_exp ? 32'd1 : 32'd0);
      if (rd_exp) check_eq("R2 read address", raddr, sal);
      check_eq("R10 write count", nw, 32'd1);
      check_eq("R2 write address", waddr, dal);
      check_eq("R1 write size", wwide, {31'h0, w});
      check_eq("R4 write data", wdata, exp_wd);
      check_eq("R5 source next", src_out, exp_src);
      check_eq("R5 dest next", dst_out, exp_dst);
      check_eq("R6 source error", {31'h0, src_adj_err}, {31'h0, sa == 2'd3});
      check_eq("R7 count", {18'h0, cnt_out}, {18'h0, c - 14'd1});
      check_eq("R8 block end", {31'h0, blk_end}, {31'h0, last});
      check_eq("R8 irq", {31'h0, irq}, {31'h0, last && ie});
      check_eq("R9 enable clear", {31'h0, en_clr}, {31'h0, last && !rp});
      check_eq("R10 idle at done", {31'h0, busy}, 32'h0);
      @(negedge clk);
      #1;
      check_eq("R8 irq single cycle", {31'h0, irq}, 32'h0);
      check_eq("R10 done single cycle", {31'h0, done}, 32'h0);
      check_eq("R10 no restart", {31'h0, busy}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check_eq("R11 reset valid", {31'h0, bus_req_valid}, 32'h0);
      check_eq("R11 reset pulses", {28'h0, done, irq, blk_end, en_clr}, 32'h0);
      check_eq("R11 reset src_out", src_out, 32'h0);
      check_eq("R11 reset count", {18'h0, cnt_out}, 32'h0);
      rst_n = 1'b1;

      // near-exhaustive sweep: size x adjust pair x lane x floor side
      for (int i = 0; i < 256; i++) begin
         logic [31:0] s, d;
         bit w, hi;
         logic [1:0] sa, da, lane;
         w = i[7]; sa = i[6:5]; da = i[4:3]; lane = i[2:1]; hi = i[0];
         s = (hi ? 32'h0400_0000 : 32'h0000_1000) + 32'(i) * 32'd8 + {30'h0, lane};
         d = 32'h0300_0000 + 32'(i) * 32'd16 + {30'h0, lane};
         run_step(w, sa, da, i[3], i[4], s, d, 14'((i % 3) + 1), i[1], 1'b0);
      end

      // floor boundary (R3)
      run_step(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 32'h01FF_FFFF, 32'h0300_0002, 14'd9, 1'b0, 1'b0);
      run_step(1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0200_0001, 32'h0300_0006, 14'd9, 1'b0, 1'b0);
      run_step(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0200_0003, 32'h0300_0000, 14'd9, 1'b1, 1'b0);
      // wrap (R5)
      run_step(1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFE, 14'd9, 1'b0, 1'b0);
      run_step(1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 14'd9, 1'b0, 1'b0);
      // count wrap from zero (R7)
      run_step(1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 32'h0500_0000, 32'h0300_0000, 14'd0, 1'b0, 1'b0);
      // block end combinations (R8, R9)
      for (int k = 0; k < 4; k++)
         run_step(1'b1, 2'd0, 2'd3, k[0], k[1], 32'h0600_0000, 32'h0300_0100, 14'd1, k[0], 1'b0);
      // inputs changed and request held during a step are ignored (R10)
      run_step(1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 32'h0700_0010, 32'h0300_0200, 14'd1, 1'b1, 1'b1);
      run_step(1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 32'h0000_0022, 32'h0300_0302, 14'd2, 1'b0, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule